// File: doc/BRIEF.md
# I2C Bus-Busy Tracker with Idle Timeout

This block watches the SCL and SDA lines of a multi-master I2C/SMBus segment and keeps the bus-busy flag that a master engine consults before asking for the bus. Both lines pass through a synchroniser. A Start condition sets the flag and a Stop condition clears it. A quiet-time counter runs alongside. Any edge on either line resets it, and it measures how long the lines have been unchanged.

Two problems are covered. Right after the module is enabled, another master may already be partway through a transfer that the flag never saw. The tracker therefore withholds permission for a first master request until the lines have been quiet for the programmed timeout. Separately, several devices can each believe the bus is taken when no transfer is running. When the flag is set and the lines stay unchanged for the full timeout, the tracker raises a stall indication. That indication is the point at which a recovery Stop becomes permissible. A software clear drops the flag at once so that a pending Start can go out.

The controller is a five-state machine:
- OFF: the module is disabled.
- SETTLE: the module is enabled but the bus state is not yet known.
- FREE: the bus is known to be idle.
- HELD: a Start has been seen.
- STALL: the flag is set but the lines have gone quiet.

Transitions:
- Any state goes to OFF when enable is low.
- OFF goes to SETTLE when enable is high.
- SETTLE goes to HELD on a Start, or to FREE on timeout expiry with no edge in that cycle.
- FREE goes to HELD on a Start.
- HELD goes to FREE on a Stop, or to STALL on expiry with no edge.
- STALL goes to FREE on a Stop, or to HELD on any other line edge.
- Every enabled state goes to FREE on software clear. The clear wins over every other event.

Top module: `bus_busy_tracker`

## Requirements
- R1: A Start, meaning SDA falling while SCL is high, sets `busy` from FREE, SETTLE or OFF-then-enabled states. The change is seen at the port after the third rising clock edge that follows the input change: two synchroniser stages plus the state register.
- R2: A Stop, meaning SDA rising while SCL is high, clears `busy` and sets `master_ok` with the same three-edge latency.
- R3: Out of reset, and on the edge after `en` is sampled low, `busy`, `master_ok` and `stuck` are all 0.
- R4: After `en` rises, `busy` and `master_ok` stay 0 until the synchronised lines have been unchanged for `tmo` clock edges. Only then does `master_ok` become 1.
- R5: A Start seen while settling sets `busy` and leaves `master_ok` at 0.
- R6: `master_ok` is 1 only when the module is enabled, has settled, and `busy` is 0. It is never 1 together with `busy` or `stuck`.
- R7: While `busy` is 1 and the synchronised lines stay unchanged, the idle count grows by one per clock. Once it reaches `tmo`, `stuck` becomes 1 and `busy` stays 1.
- R8: Any SCL or SDA edge while `stuck` is 1, other than a Stop, clears `stuck`, keeps `busy` at 1, and restarts the idle count.
- R9: `sw_clr` sampled high on an enabled edge makes `busy` and `stuck` 0 and `master_ok` 1 after that edge. It takes priority over a simultaneous Start.
- R10: SDA changes while SCL is low are neither Start nor Stop, so they leave `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| sw_clr | input | 1 | Software clear of the busy flag |
| tmo | input | CNT_W | Idle timeout in clock cycles |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| busy | output | 1 | Bus-busy flag |
| master_ok | output | 1 | Bus confirmed idle; a master request may be issued |
| stuck | output | 1 | Busy with the lines quiet for the full timeout |

## Verification
The bench builds the tracker with `CNT_W = 6` and the default two synchroniser stages. With a 6-bit counter, timeouts of 4 to 20 cycles let the settle, stall and recovery paths all be reached many times within a short random run. The counter's saturation limit of 63 also comes within reach. A reference model derived from the requirements runs alongside random line activity, random enable drops and random clears, so that Start/Stop detection and expiry are exercised in every state of the machine.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    typedef enum logic [2:0] {
        BB_OFF    = 3'd0,
        BB_SETTLE = 3'd1,
        BB_FREE   = 3'd2,
        BB_HELD   = 3'd3,
        BB_STALL  = 3'd4
    } bb_state_t;
endpackage

// File: rtl/bbt_sync.sv
// Multi-stage synchroniser, one chain per line, reset to the released (high) level.
module bbt_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] d,
    output logic [N_LINES-1:0] q
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d[i];
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d[i]};
            end
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/bbt_cond.sv
// Start / Stop / edge detection on synchronised lines.
module bbt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic edge_p
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    logic scl_hi;
    assign scl_hi  = scl_s & scl_q;
    assign start_p = scl_hi & sda_q & ~sda_s;
    assign stop_p  = scl_hi & ~sda_q & sda_s;
    assign edge_p  = (scl_s ^ scl_q) | (sda_s ^ sda_q);
endmodule

// File: rtl/bbt_idle_cnt.sv
// Saturating quiet-time counter; cleared by any line edge or while disabled.
module bbt_idle_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_p,
    input  logic [CNT_W-1:0] tmo,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!en || edge_p)  cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= tmo);
endmodule

// File: rtl/bbt_fsm.sv
// Bus-state controller: state register, next-state logic, output decode.
module bbt_fsm
    import bbt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      clr,
    input  logic      start_p,
    input  logic      stop_p,
    input  logic      edge_p,
    input  logic      expired,
    output bb_state_t state,
    output logic      busy,
    output logic      master_ok,
    output logic      stuck
);
    bb_state_t nxt;
    logic      quiet_done;

    assign quiet_done = expired & ~edge_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BB_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = BB_OFF;
        end else begin
            unique case (state)
                BB_OFF:    nxt = BB_SETTLE;
                BB_SETTLE: begin
                    if (clr)             nxt = BB_FREE;
                    else if (start_p)    nxt = BB_HELD;
                    else if (quiet_done) nxt = BB_FREE;
                end
                BB_FREE: begin
                    if (!clr && start_p) nxt = BB_HELD;
                end
                BB_HELD: begin
                    if (clr || stop_p)   nxt = BB_FREE;
                    else if (quiet_done) nxt = BB_STALL;
                end
                BB_STALL: begin
                    if (clr || stop_p)   nxt = BB_FREE;
                    else if (edge_p)     nxt = BB_HELD;
                end
                default:                 nxt = BB_OFF;
            endcase
        end
    end

    always_comb begin
        busy      = 1'b0;
        master_ok = 1'b0;
        stuck     = 1'b0;
        unique case (state)
            BB_OFF, BB_SETTLE: ;
            BB_FREE:  master_ok = 1'b1;
            BB_HELD:  busy      = 1'b1;
            BB_STALL: begin
                busy  = 1'b1;
                stuck = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_busy_tracker.sv
module bus_busy_tracker
    import bbt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sw_clr,
    input  logic [CNT_W-1:0] tmo,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             busy,
    output logic             master_ok,
    output logic             stuck
);
    localparam int N_LINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [N_LINES-1:0] lines_s;
    logic               start_p, stop_p, edge_p, expired;
    bb_state_t          state;

    bbt_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_in, scl_in}),
        .q     (lines_s)
    );

    bbt_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (lines_s[IDX_SCL]),
        .sda_s   (lines_s[IDX_SDA]),
        .start_p (start_p),
        .stop_p  (stop_p),
        .edge_p  (edge_p)
    );

    bbt_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .edge_p  (edge_p),
        .tmo     (tmo),
        .expired (expired)
    );

    bbt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .clr       (sw_clr),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .edge_p    (edge_p),
        .expired   (expired),
        .state     (state),
        .busy      (busy),
        .master_ok (master_ok),
        .stuck     (stuck)
    );
endmodule

// File: rtl/bus_busy_tracker_chk.sv
module bus_busy_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sw_clr,
    input logic busy,
    input logic master_ok,
    input logic stuck
);
    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!busy && !master_ok && !stuck));

    // R4
    settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> !master_ok);

    // R6
    ok_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_ok |-> (!busy && !stuck));

    // R7
    stuck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck |-> busy);

    // R7
    stuck_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck) |-> $past(busy));

    // R9
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_clr) |-> !busy);
endmodule

bind bus_busy_tracker bus_busy_tracker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sw_clr    (sw_clr),
    .busy      (busy),
    .master_ok (master_ok),
    .stuck     (stuck)
);

// File: tb/bus_busy_tracker_bench.sv
module bus_busy_tracker_bench;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          sw_clr = 1'b0;
    logic [CW-1:0] tmo = 6'd8;
    logic          scl_in = 1'b1;
    logic          sda_in = 1'b1;
    logic          busy, master_ok, stuck;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    bus_busy_tracker #(.CNT_W(CW), .SYNC_STAGES(2)) u_bus_busy_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sw_clr    (sw_clr),
        .tmo       (tmo),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .busy      (busy),
        .master_ok (master_ok),
        .stuck     (stuck)
    );

    // Reference model built from the requirements (0 off,1 settle,2 free,3 held,4 stall)
    logic [1:0] m_scl, m_sda;   // two synchroniser stages
    logic       p_scl, p_sda;   // previous synchronised level
    logic [CW-1:0] m_cnt;
    int         m_st;

    function automatic logic exp_busy(int s);
        return (s == 3) || (s == 4);
    endfunction
    function automatic logic exp_ok(int s);
        return s == 2;
    endfunction
    function automatic logic exp_stuck(int s);
        return s == 4;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_scl <= 2'b11; m_sda <= 2'b11;
            p_scl <= 1'b1;  p_sda <= 1'b1;
            m_cnt <= '0;    m_st  <= 0;
        end else begin
            logic s_c, s_d, ed, st, sp, qd;
            int   n;
            s_c = m_scl[1];
            s_d = m_sda[1];
            ed  = (s_c != p_scl) || (s_d != p_sda);
            st  = s_c && p_scl && p_sda && !s_d;
            sp  = s_c && p_scl && !p_sda && s_d;
            qd  = (m_cnt >= tmo) && !ed;
            n   = m_st;
            if (!en) n = 0;
            else if (m_st == 0) n = 1;
            else if (sw_clr) n = 2;
            else if (m_st == 1) begin
                if (st) n = 3; else if (qd) n = 2;
            end else if (m_st == 2) begin
                if (st) n = 3;
            end else if (m_st == 3) begin
                if (sp) n = 2; else if (qd) n = 4;
            end else if (m_st == 4) begin
                if (sp) n = 2; else if (ed) n = 3;
            end
            m_st  <= n;
            m_scl <= {m_scl[0], scl_in};
            m_sda <= {m_sda[0], sda_in};
            p_scl <= s_c;
            p_sda <= s_d;
            if (!en || ed) m_cnt <= '0;
            else if (m_cnt != {CW{1'b1}}) m_cnt <= m_cnt + 1'b1;
        end
    end

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, expv);
        end
    endtask

    // Advance to the next falling edge and compare all outputs with the model.
    task automatic tick();
        @(negedge clk);
        check("R1/R2 busy vs model", busy, exp_busy(m_st));
        check("R6 master_ok vs model", master_ok, exp_ok(m_st));
        check("R7 stuck vs model", stuck, exp_stuck(m_st));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset busy", busy, 1'b0);
        check("R3 reset master_ok", master_ok, 1'b0);
        check("R3 reset stuck", stuck, 1'b0);

        // R4: settling after enable
        en = 1'b1; tmo = 6'd8;
        ticks(3);
        check("R4 settling master_ok", master_ok, 1'b0);
        check("R4 settling busy", busy, 1'b0);
        ticks(12);
        check("R4 settled master_ok", master_ok, 1'b1);

        // R1: Start, latency of three rising edges
        sda_in = 1'b0;
        ticks(2);
        check("R1 busy not yet", busy, 1'b0);
        tick();
        check("R1 busy after start", busy, 1'b1);
        check("R6 ok low while busy", master_ok, 1'b0);

        // R10: SDA moves while SCL low
        scl_in = 1'b0; ticks(2);
        sda_in = 1'b1; ticks(2);
        sda_in = 1'b0; ticks(4);
        check("R10 busy kept", busy, 1'b1);

        // R7: quiet while busy
        ticks(int'(tmo) + 6);
        check("R7 stuck", stuck, 1'b1);
        check("R7 busy held", busy, 1'b1);

        // R8: any edge leaves stall
        scl_in = 1'b1; ticks(4);
        check("R8 stuck cleared", stuck, 1'b0);
        check("R8 busy kept", busy, 1'b1);

        // R2: Stop
        sda_in = 1'b1; ticks(3);
        check("R2 busy cleared", busy, 1'b0);
        check("R2 master_ok", master_ok, 1'b1);

        // R9: software clear
        sda_in = 1'b0; ticks(4);
        check("R9 pre busy", busy, 1'b1);
        sw_clr = 1'b1; tick(); sw_clr = 1'b0;
        check("R9 busy dropped", busy, 1'b0);
        check("R9 master_ok", master_ok, 1'b1);

        // R3: disable while busy
        sda_in = 1'b1; ticks(4);
        sda_in = 1'b0; ticks(4);
        en = 1'b0; tick();
        check("R3 disabled busy", busy, 1'b0);
        check("R3 disabled ok", master_ok, 1'b0);
        sda_in = 1'b1; ticks(4);

        // R5: Start during settle
        en = 1'b1; ticks(2);
        check("R4 re-enable ok", master_ok, 1'b0);
        sda_in = 1'b0; ticks(3);
        check("R5 busy in settle", busy, 1'b1);
        check("R5 ok stays low", master_ok, 1'b0);
        sda_in = 1'b1; ticks(4);

        // R10 in FREE: SDA toggles with SCL low
        scl_in = 1'b0; ticks(2);
        sda_in = 1'b0; ticks(2);
        sda_in = 1'b1; ticks(3);
        check("R10 busy stays low", busy, 1'b0);
        scl_in = 1'b1; ticks(3);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 30)      ticks($urandom_range(1, int'(tmo) + 4));
            else if (r < 60) begin scl_in = ~scl_in; tick(); end
            else if (r < 90) begin sda_in = ~sda_in; tick(); end
            else if (r < 94) begin sw_clr = 1'b1; tick(); sw_clr = 1'b0; end
            else if (r < 96) begin en = ~en; tick(); end
            else if (r < 98) begin tmo = 6'($urandom_range(4, 20)); tick(); end
            else begin
                if (!en) en = 1'b1;
                tick();
            end
        end
        en = 1'b1;
        ticks(10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule